// File: doc/BRIEF.md
# Double-Buffered Crosspoint Router

This block is a non-blocking crosspoint router. It has N_IN single-bit data inputs and N_OUT single-bit data outputs, 32 of each by default. Each output has its own multiplexer that picks one input. Any input may feed one output, several outputs or all outputs at once. The path from input to output is purely combinational. No clocked stage lies between a data input and a data output.

The routing pattern is stored at two levels. A staging register and an active register exist for each output. A rising edge on the configuration strobe writes a select code into the staging register of one addressed output. With broadcast enabled, the write goes to every staging register. A level on the commit strobe copies all staging registers into the active registers on the same clock edge, so the whole pattern changes in one step. When flow-through is enabled, the active registers track the staging registers, and a write takes effect on the edge that performs it. The strobes and the mode inputs are sampled on the rising edge of `clk`. The reset is asynchronous and active-low, and its release is synchronised to `clk`.

Top module: `xbar_crosspoint`

## Requirements
- R1: Reset clears every staging and active register to code 0, so every output carries input 0 until a new pattern is committed.
- R2: Output j always equals input k, where k is the select code in the active register of output j. Code 0 selects input 0, code 1 selects input 1, and so on. Inputs reach the outputs with no clock edge on the way.
- R3: A write happens at the first rising clock edge at which `cfg_stb` is sampled high after it was sampled low. The write stores `cfg_sel` in the staging register of the output whose index equals `cfg_addr` (address 0 is output 0), and leaves all other staging registers as they were.
- R4: While `flow_en` and `commit_stb` are both low, staging writes leave every output's routing unchanged.
- R5: At each clock edge where `commit_stb` is sampled high and `flow_en` is low, every active register takes the value its staging register held before that edge.
- R6: A write with `bcast_en` high stores `cfg_sel` in all staging registers and ignores `cfg_addr`. After a commit, one input drives every output.
- R7: While `flow_en` is high, each active register is loaded with its staging register's new value at every edge, so a write changes routing at the same edge, with no commit.
- R8: When `cfg_stb` stays high over several edges, only the first of those edges writes. Changes to `cfg_sel` or `cfg_addr` while the strobe stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration sampling |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_stb | input | 1 | Configuration write strobe. A low-to-high change triggers one write. |
| cfg_addr | input | ADDR_W (5) | Index of the output whose staging register is written |
| cfg_sel | input | SEL_W (5) | Input index to store as the new select code |
| commit_stb | input | 1 | While high, copies all staging registers into the active registers |
| bcast_en | input | 1 | Makes a write go to every staging register |
| flow_en | input | 1 | Makes the active registers track the staging registers |
| din | input | N_IN (32) | Data inputs |
| dout | output | N_OUT (32) | Data outputs |

## Verification
The bench looks for leakage between the two storage levels. After a full set of staged writes and before the commit, it checks that the routing is still the old one. A design that wires a write straight to the active level would already show the new pattern at that point. It holds the strobe high while it changes the data, which catches a design that writes on the level instead of on the edge. It checks each output's exact source with a walking-one pattern on the inputs. This exposes a write that lands on the wrong output, a broadcast that still obeys the address, and a flow-through mode that waits for a commit.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // How the active select bank is loaded at the next edge
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_COMMIT = 2'd1,
    ACT_TRACK  = 2'd2
  } act_mode_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank
  import xbar_pkg::*;
#(
  parameter int unsigned N_OUT  = 32,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic              wr_bcast,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              commit,
  input  logic              track,
  output logic [SEL_W-1:0]  stage_q [N_OUT],
  output logic [SEL_W-1:0]  act_q   [N_OUT]
);
  logic [SEL_W-1:0] stage_d [N_OUT];
  logic [SEL_W-1:0] act_d   [N_OUT];
  act_mode_e        mode;
  logic             stage_en;
  logic             act_en;

  // staging next state
  always_comb begin
    for (int j = 0; j < N_OUT; j++) begin
      stage_d[j] = stage_q[j];
      if (wr_pulse && (wr_bcast || (wr_addr == ADDR_W'(j))))
        stage_d[j] = wr_sel;
    end
  end

  // active load mode: tracking wins over commit
  always_comb begin
    if (track)       mode = ACT_TRACK;
    else if (commit) mode = ACT_COMMIT;
    else             mode = ACT_KEEP;
  end

  always_comb begin
    for (int j = 0; j < N_OUT; j++) begin
      unique case (mode)
        ACT_TRACK:  act_d[j] = stage_d[j];
        ACT_COMMIT: act_d[j] = stage_q[j];
        default:    act_d[j] = act_q[j];
      endcase
    end
  end

  assign stage_en = wr_pulse;
  assign act_en   = (mode != ACT_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_OUT; j++) stage_q[j] <= '0;
    end else if (stage_en) begin
      for (int j = 0; j < N_OUT; j++) stage_q[j] <= stage_d[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_OUT; j++) act_q[j] <= '0;
    end else if (act_en) begin
      for (int j = 0; j < N_OUT; j++) act_q[j] <= act_d[j];
    end
  end
endmodule

// File: rtl/xbar_mux_array.sv
module xbar_mux_array #(
  parameter int unsigned N_IN  = 32,
  parameter int unsigned N_OUT = 32,
  parameter int unsigned SEL_W = 5
) (
  input  logic [N_IN-1:0]  din,
  input  logic [SEL_W-1:0] sel [N_OUT],
  output logic [N_OUT-1:0] dout
);
  localparam bit FULL_RANGE = ((1 << SEL_W) == N_IN);

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    if (FULL_RANGE) begin : g_full
      assign dout[j] = din[sel[j]];
    end else begin : g_part
      // codes beyond the last input drive a constant low
      assign dout[j] = (32'(sel[j]) < N_IN) ? din[sel[j]] : 1'b0;
    end
  end
endmodule

// File: rtl/xbar_crosspoint.sv
module xbar_crosspoint
  import xbar_pkg::*;
#(
  parameter int unsigned N_IN  = 32,
  parameter int unsigned N_OUT = 32,
  localparam int unsigned SEL_W  = idx_width(N_IN),
  localparam int unsigned ADDR_W = idx_width(N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stb,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              commit_stb,
  input  logic              bcast_en,
  input  logic              flow_en,
  input  logic [N_IN-1:0]   din,
  output logic [N_OUT-1:0]  dout
);
  logic             rst_s_n;
  logic             stb_q;
  logic             wr_pulse;
  logic [SEL_W-1:0] stage_q [N_OUT];
  logic [SEL_W-1:0] act_q   [N_OUT];
  logic [N_OUT*SEL_W-1:0] stage_flat;
  logic [N_OUT*SEL_W-1:0] act_flat;

  xbar_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // rising-edge detect on the write strobe
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) stb_q <= 1'b0;
    else          stb_q <= cfg_stb;
  end

  assign wr_pulse = cfg_stb & ~stb_q;

  xbar_cfg_bank #(
    .N_OUT  (N_OUT),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_pulse (wr_pulse),
    .wr_bcast (bcast_en),
    .wr_addr  (cfg_addr),
    .wr_sel   (cfg_sel),
    .commit   (commit_stb),
    .track    (flow_en),
    .stage_q  (stage_q),
    .act_q    (act_q)
  );

  xbar_mux_array #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .SEL_W (SEL_W)
  ) u_mux (
    .din  (din),
    .sel  (act_q),
    .dout (dout)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_flat
    assign stage_flat[j*SEL_W +: SEL_W] = stage_q[j];
    assign act_flat[j*SEL_W +: SEL_W]   = act_q[j];
  end
endmodule

// File: rtl/xbar_crosspoint_chk.sv
module xbar_crosspoint_chk #(
  parameter int unsigned N_IN   = 32,
  parameter int unsigned N_OUT  = 32,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned ADDR_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rst_s_n,
  input logic                   cfg_stb,
  input logic [SEL_W-1:0]       cfg_sel,
  input logic                   commit_stb,
  input logic                   bcast_en,
  input logic                   flow_en,
  input logic [N_IN-1:0]        din,
  input logic [N_OUT-1:0]       dout,
  input logic [N_OUT*SEL_W-1:0] stage_flat,
  input logic [N_OUT*SEL_W-1:0] act_flat
);
  function automatic logic all_hold(input logic [N_OUT*SEL_W-1:0] v,
                                    input logic [SEL_W-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < N_OUT; j++)
      if (v[j*SEL_W +: SEL_W] != s) ok = 1'b0;
    return ok;
  endfunction

  // R1: both banks cleared when reset releases
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_s_n) |-> (stage_flat == '0 && act_flat == '0));

  // R2: each output follows the input named by its active code
  for (genvar j = 0; j < N_OUT; j++) begin : g_route
    if (((1 << SEL_W) == N_IN)) begin : g_chk
      p_route_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
        dout[j] == din[act_flat[j*SEL_W +: SEL_W]]);
    end
  end

  // R4: no commit and no tracking leaves the active bank alone
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!commit_stb && !flow_en) |=> $stable(act_flat));

  // R5: commit copies the pre-edge staging bank
  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (commit_stb && !flow_en) |=> (act_flat == $past(stage_flat)));

  // R6: broadcast write fills every staging register
  p_bcast_fill_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_stb && !$past(cfg_stb) && bcast_en) |=> all_hold(stage_flat, $past(cfg_sel)));

  // R7: tracking mode keeps both banks equal after each edge
  p_flow_track_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    flow_en |=> (act_flat == stage_flat));

  // R8: a strobe held high writes nothing further
  p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_stb && $past(cfg_stb)) |=> $stable(stage_flat));
endmodule

bind xbar_crosspoint xbar_crosspoint_chk #(
  .N_IN   (N_IN),
  .N_OUT  (N_OUT),
  .SEL_W  (SEL_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_s_n    (rst_s_n),
  .cfg_stb    (cfg_stb),
  .cfg_sel    (cfg_sel),
  .commit_stb (commit_stb),
  .bcast_en   (bcast_en),
  .flow_en    (flow_en),
  .din        (din),
  .dout       (dout),
  .stage_flat (stage_flat),
  .act_flat   (act_flat)
);

// File: tb/xbar_crosspoint_tb_top.sv
module xbar_crosspoint_tb_top;
  localparam int CLK_P  = 10;
  localparam int N_IN   = 32;
  localparam int N_OUT  = 32;
  localparam int SEL_W  = 5;
  localparam int ADDR_W = 5;

  logic              clk;
  logic              rst_n;
  logic              cfg_stb;
  logic [ADDR_W-1:0] cfg_addr;
  logic [SEL_W-1:0]  cfg_sel;
  logic              commit_stb;
  logic              bcast_en;
  logic              flow_en;
  logic [N_IN-1:0]   din;
  logic [N_OUT-1:0]  dout;

  int checks;
  int failures;
  int stage_m [N_OUT];
  int act_m   [N_OUT];

  xbar_crosspoint #(.N_IN(N_IN), .N_OUT(N_OUT)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_stb    (cfg_stb),
    .cfg_addr   (cfg_addr),
    .cfg_sel    (cfg_sel),
    .commit_stb (commit_stb),
    .bcast_en   (bcast_en),
    .flow_en    (flow_en),
    .din        (din),
    .dout       (dout)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // walking one over the inputs; each output must light only for its source
  task automatic check_routes(input string req);
    for (int i = 0; i < N_IN; i++) begin
      logic [N_OUT-1:0] exp;
      din = N_IN'(1) << i;
      for (int j = 0; j < N_OUT; j++) exp[j] = (act_m[j] == i);
      #1;
      checks++;
      if (dout !== exp) begin
        failures++;
        $display("FAIL %s input=%0d actual=%h expected=%h", req, i, dout, exp);
      end
    end
    din = '0;
  endtask

  task automatic do_write(input int addr, input int sel, input logic bc);
    @(negedge clk);
    cfg_addr = ADDR_W'(addr);
    cfg_sel  = SEL_W'(sel);
    bcast_en = bc;
    cfg_stb  = 1'b1;
    @(negedge clk);
    cfg_stb  = 1'b0;
    bcast_en = 1'b0;
    for (int j = 0; j < N_OUT; j++)
      if (bc || j == addr) stage_m[j] = sel;
    if (flow_en) act_m = stage_m;
  endtask

  task automatic do_commit();
    @(negedge clk);
    commit_stb = 1'b1;
    @(negedge clk);
    commit_stb = 1'b0;
    act_m = stage_m;
  endtask

  task automatic t_reset();
    check_routes("R1");
  endtask

  task automatic t_stage_then_commit();
    for (int j = 0; j < N_OUT; j++) do_write(j, (j * 7 + 3) % N_IN, 1'b0);
    check_routes("R4");
    do_commit();
    check_routes("R5");
    // single-output rewrite must touch only that output (R3)
    do_write(12, 30, 1'b0);
    do_commit();
    check_routes("R3");
  endtask

  task automatic t_strobe_level();
    @(negedge clk);
    cfg_addr = ADDR_W'(4);
    cfg_sel  = SEL_W'(21);
    cfg_stb  = 1'b1;
    @(negedge clk);
    cfg_sel  = SEL_W'(9);
    cfg_addr = ADDR_W'(6);
    @(negedge clk);
    cfg_stb  = 1'b0;
    stage_m[4] = 21;
    do_commit();
    check_routes("R8");
  endtask

  task automatic t_broadcast();
    do_write(5, 17, 1'b1);
    check_routes("R4");
    do_commit();
    check_routes("R6");
  endtask

  task automatic t_flow();
    @(negedge clk);
    flow_en = 1'b1;
    do_write(3, 9, 1'b0);
    check_routes("R7");
    do_write(20, 2, 1'b0);
    check_routes("R7");
    @(negedge clk);
    flow_en = 1'b0;
    do_write(0, 31, 1'b0);
    check_routes("R4");
    do_commit();
    check_routes("R2");
  endtask

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    cfg_stb = 1'b0;
    cfg_addr = '0;
    cfg_sel = '0;
    commit_stb = 1'b0;
    bcast_en = 1'b0;
    flow_en = 1'b0;
    din = '0;
    for (int j = 0; j < N_OUT; j++) begin
      stage_m[j] = 0;
      act_m[j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stage_then_commit();
    t_strobe_level();
    t_broadcast();
    t_flow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule